// File: doc/BRIEF.md
# March C- Memory Self-Test Engine

This block runs a destructive built-in self-test on one synchronous single-port SRAM. After a start request it takes over the memory's address, write-data, write-enable and read-enable pins. It then runs the six March C- elements over every word, issuing one memory operation per clock. Each read is compared with the value the algorithm expects. The first mismatch is recorded, and the run carries on to the end.

A start request is a single-cycle pulse. It is honoured only when the external debug-enable input is high at that moment. If debug-enable drops while a test is running, the run stops at once and an abort flag is raised. The status outputs show busy, a done pulse, a sticky fail flag, the abort flag, and the address, element number and read data of the first failure.

Top module: `mbist_march_top`

## Requirements
- R1: A start pulse is accepted only when `dbg_en` is high and the engine is idle. A start while `dbg_en` is low causes no memory operation, leaves `busy` low and leaves `aborted` unchanged.
- R2: A run applies six elements in this order, where pattern 0 is every data bit zero and pattern 1 is every data bit one: 1 write 0; 2 read 0 then write 1; 3 read 1 then write 0; 4 read 0 then write 1; 5 read 1 then write 0; 6 read 0.
- R3: Elements 1 to 3 visit addresses 0 up to 2^AW-1. Elements 4 to 6 visit addresses 2^AW-1 down to 0.
- R4: In elements 2 to 5, a word's read happens in the cycle just before the write to that same address, and the address moves on only after that write.
- R5: One memory operation is issued per cycle, never a read and a write together. A complete run issues exactly 10·2^AW operations.
- R6: Read data is compared in the cycle after the read. The first mismatch sets the sticky `fail` flag and captures the address, the element number (1 to 6) and the read data. Later mismatches change none of these, and the run completes.
- R7: `busy` rises on the edge that accepts a start and stays high through the compare of the last element-6 read, which is 10·2^AW+1 cycles. `done` is a one-cycle pulse on the edge where `busy` falls.
- R8: If `dbg_en` is low while `busy` is high, on the next edge `busy` clears, `aborted` sets, no further operation is issued and `done` does not pulse.
- R9: An accepted start clears `fail`, `aborted` and the capture fields.
- R10: After a complete run every memory word holds pattern 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dbg_en | input | 1 | External debug enable that gates start and keeps the run alive |
| start | input | 1 | Single-cycle start request |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Memory write data |
| mem_we | output | 1 | Memory write enable |
| mem_re | output | 1 | Memory read enable (data returned next cycle) |
| mem_rdata | input | DW | Memory read data |
| busy | output | 1 | Test in progress |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | Sticky mismatch flag |
| aborted | output | 1 | Last run was stopped by dbg_en falling |
| fail_addr | output | AW | Address of first mismatch |
| fail_elem | output | 3 | Element number (1 to 6) of first mismatch |
| fail_data | output | DW | Read data of first mismatch |

## Verification
A wrong element index, address direction or phase shows up at the memory pins in the very cycle it happens. The scoreboard compares every issued operation against the independently generated March C- stream, so the first wrong operation is reported as it appears. Compare-path faults need an injected stuck-at memory bit. The expected first-failure address, element and data are known in advance, and they appear one cycle after the faulty read. Abort and gating errors appear on `busy` and `aborted` one edge after `dbg_en` changes.

// File: rtl/mbist_pkg.sv
package mbist_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_DRAIN = 2'd2
  } mb_state_e;

  localparam int unsigned ELEM_W    = 3;
  localparam logic [2:0]  ELEM_LAST = 3'd5;

  // element index is zero based internally: 0..5
  function automatic logic elem_reads(input logic [2:0] e);
    return e != 3'd0;
  endfunction

  function automatic logic elem_writes(input logic [2:0] e);
    return e != ELEM_LAST;
  endfunction

  function automatic logic elem_down(input logic [2:0] e);
    return e >= 3'd3;
  endfunction

  function automatic logic elem_rd_one(input logic [2:0] e);
    return (e == 3'd2) || (e == 3'd4);
  endfunction

  function automatic logic elem_wr_one(input logic [2:0] e);
    return (e == 3'd1) || (e == 3'd3);
  endfunction

endpackage

// File: rtl/mbist_seq.sv
module mbist_seq
  import mbist_pkg::*;
#(
  parameter int unsigned AW = 4,
  parameter int unsigned DW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dbg_en,
  input  logic              start,
  output logic [AW-1:0]     mem_addr,
  output logic [DW-1:0]     mem_wdata,
  output logic              mem_we,
  output logic              mem_re,
  output logic              busy,
  output logic              done,
  output logic              aborted,
  output logic              start_acc,
  output logic              cmp_vld,
  output logic [DW-1:0]     cmp_exp,
  output logic [AW-1:0]     cmp_addr,
  output logic [ELEM_W-1:0] cmp_elem
);

  localparam logic [AW-1:0] ADDR_TOP = {AW{1'b1}};
  localparam logic          PH_RD    = 1'b0;
  localparam logic          PH_WR    = 1'b1;

  mb_state_e         st_q, st_d;
  logic [2:0]        elem_q, elem_d;
  logic [AW-1:0]     addr_q, addr_d;
  logic              ph_q, ph_d;
  logic              busy_q, busy_d;
  logic              done_q, done_d;
  logic              abt_q, abt_d;
  logic [2:0]        elem_nx;
  logic [AW-1:0]     end_addr;
  logic              in_run;

  assign elem_nx  = 3'(elem_q + 3'd1);
  assign end_addr = elem_down(elem_q) ? '0 : ADDR_TOP;
  assign in_run   = (st_q == ST_RUN);

  // next-state logic
  always_comb begin
    st_d      = st_q;
    elem_d    = elem_q;
    addr_d    = addr_q;
    ph_d      = ph_q;
    busy_d    = busy_q;
    done_d    = 1'b0;
    abt_d     = abt_q;
    start_acc = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start && dbg_en) begin
          start_acc = 1'b1;
          st_d      = ST_RUN;
          elem_d    = 3'd0;
          addr_d    = '0;
          ph_d      = PH_WR;
          busy_d    = 1'b1;
          abt_d     = 1'b0;
        end
      end
      ST_RUN: begin
        if (!dbg_en) begin
          st_d   = ST_IDLE;
          busy_d = 1'b0;
          abt_d  = 1'b1;
        end else if (elem_reads(elem_q) && elem_writes(elem_q) && (ph_q == PH_RD)) begin
          ph_d = PH_WR;
        end else if (addr_q == end_addr) begin
          if (elem_q == ELEM_LAST) begin
            st_d = ST_DRAIN;
          end else begin
            elem_d = elem_nx;
            addr_d = elem_down(elem_nx) ? ADDR_TOP : '0;
            ph_d   = PH_RD;
          end
        end else begin
          addr_d = elem_down(elem_q) ? AW'(addr_q - 1'b1) : AW'(addr_q + 1'b1);
          ph_d   = elem_reads(elem_q) ? PH_RD : PH_WR;
        end
      end
      ST_DRAIN: begin
        st_d   = ST_IDLE;
        busy_d = 1'b0;
        if (!dbg_en) begin
          abt_d = 1'b1;
        end else begin
          done_d = 1'b1;
        end
      end
      default: begin
        st_d   = ST_IDLE;
        busy_d = 1'b0;
      end
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      elem_q <= 3'd0;
      addr_q <= '0;
      ph_q   <= PH_WR;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      abt_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      elem_q <= elem_d;
      addr_q <= addr_d;
      ph_q   <= ph_d;
      busy_q <= busy_d;
      done_q <= done_d;
      abt_q  <= abt_d;
    end
  end

  assign mem_re    = in_run && (ph_q == PH_RD);
  assign mem_we    = in_run && (ph_q == PH_WR);
  assign mem_addr  = addr_q;
  assign mem_wdata = elem_wr_one(elem_q) ? {DW{1'b1}} : {DW{1'b0}};

  // compare pipeline: aligns expected value with one-cycle read latency
  logic              cv_q;
  logic [DW-1:0]     ce_q;
  logic [AW-1:0]     ca_q;
  logic [ELEM_W-1:0] cl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cv_q <= 1'b0;
      ce_q <= '0;
      ca_q <= '0;
      cl_q <= '0;
    end else begin
      cv_q <= mem_re;
      if (mem_re) begin
        ce_q <= elem_rd_one(elem_q) ? {DW{1'b1}} : {DW{1'b0}};
        ca_q <= addr_q;
        cl_q <= elem_q;
      end
    end
  end

  assign cmp_vld  = cv_q;
  assign cmp_exp  = ce_q;
  assign cmp_addr = ca_q;
  assign cmp_elem = cl_q;
  assign busy     = busy_q;
  assign done     = done_q;
  assign aborted  = abt_q;

endmodule

// File: rtl/mbist_cmp.sv
module mbist_cmp
  import mbist_pkg::*;
#(
  parameter int unsigned AW = 4,
  parameter int unsigned DW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              cmp_vld,
  input  logic [DW-1:0]     cmp_exp,
  input  logic [AW-1:0]     cmp_addr,
  input  logic [ELEM_W-1:0] cmp_elem,
  input  logic [DW-1:0]     rdata,
  output logic              fail,
  output logic [AW-1:0]     fail_addr,
  output logic [ELEM_W-1:0] fail_elem,
  output logic [DW-1:0]     fail_data
);

  logic              fail_q;
  logic [AW-1:0]     fa_q;
  logic [ELEM_W-1:0] fe_q;
  logic [DW-1:0]     fd_q;
  logic              mism;
  logic              cap;

  always_comb begin
    mism = cmp_vld && (rdata != cmp_exp);
    cap  = mism && !fail_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fail_q <= 1'b0;
      fa_q   <= '0;
      fe_q   <= '0;
      fd_q   <= '0;
    end else if (clr) begin
      fail_q <= 1'b0;
      fa_q   <= '0;
      fe_q   <= '0;
      fd_q   <= '0;
    end else if (cap) begin
      fail_q <= 1'b1;
      fa_q   <= cmp_addr;
      fe_q   <= ELEM_W'(cmp_elem + 1'b1);
      fd_q   <= rdata;
    end
  end

  assign fail      = fail_q;
  assign fail_addr = fa_q;
  assign fail_elem = fe_q;
  assign fail_data = fd_q;

endmodule

// File: rtl/mbist_march_top.sv
module mbist_march_top
  import mbist_pkg::*;
#(
  parameter int unsigned AW = 4,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dbg_en,
  input  logic          start,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_we,
  output logic          mem_re,
  input  logic [DW-1:0] mem_rdata,
  output logic          busy,
  output logic          done,
  output logic          fail,
  output logic          aborted,
  output logic [AW-1:0] fail_addr,
  output logic [2:0]    fail_elem,
  output logic [DW-1:0] fail_data
);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  logic              start_acc;
  logic              cmp_vld;
  logic [DW-1:0]     cmp_exp;
  logic [AW-1:0]     cmp_addr;
  logic [ELEM_W-1:0] cmp_elem;

  mbist_seq #(.AW(AW), .DW(DW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .dbg_en    (dbg_en),
    .start     (start),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_we    (mem_we),
    .mem_re    (mem_re),
    .busy      (busy),
    .done      (done),
    .aborted   (aborted),
    .start_acc (start_acc),
    .cmp_vld   (cmp_vld),
    .cmp_exp   (cmp_exp),
    .cmp_addr  (cmp_addr),
    .cmp_elem  (cmp_elem)
  );

  mbist_cmp #(.AW(AW), .DW(DW)) u_cmp (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .clr       (start_acc),
    .cmp_vld   (cmp_vld),
    .cmp_exp   (cmp_exp),
    .cmp_addr  (cmp_addr),
    .cmp_elem  (cmp_elem),
    .rdata     (mem_rdata),
    .fail      (fail),
    .fail_addr (fail_addr),
    .fail_elem (fail_elem),
    .fail_data (fail_data)
  );

endmodule

// File: rtl/mbist_march_chk.sv
module mbist_march_chk #(
  parameter int unsigned AW = 4,
  parameter int unsigned DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          dbg_en,
  input logic          start,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata,
  input logic          mem_we,
  input logic          mem_re,
  input logic [DW-1:0] mem_rdata,
  input logic          busy,
  input logic          done,
  input logic          fail,
  input logic          aborted,
  input logic [AW-1:0] fail_addr,
  input logic [2:0]    fail_elem,
  input logic [DW-1:0] fail_data
);

  AST_BUSY_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start && dbg_en)); // R1

  AST_WRITE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_re)) |-> (mem_addr == $past(mem_addr))); // R4

  AST_ONE_OP: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re)); // R5

  AST_OPS_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we || mem_re) |-> busy); // R5

  AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (fail && !(!busy && start && dbg_en)) |=> fail); // R6

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7

  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy))); // R7

  AST_ABORT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !dbg_en) |=> (!busy && aborted && !done)); // R8

endmodule

bind mbist_march_top mbist_march_chk #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/mbist_march_top_tb.sv
module mbist_march_top_tb;

  localparam int AW = 4;
  localparam int DW = 8;
  localparam int N  = 1 << AW;

  logic          clk;
  logic          rst_n;
  logic          dbg_en;
  logic          start;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic          mem_we;
  logic          mem_re;
  logic [DW-1:0] mem_rdata;
  logic          busy;
  logic          done;
  logic          fail;
  logic          aborted;
  logic [AW-1:0] fail_addr;
  logic [2:0]    fail_elem;
  logic [DW-1:0] fail_data;

  mbist_march_top #(.AW(AW), .DW(DW)) u_dut (.*);

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // memory model with injectable stuck-at bits
  logic [DW-1:0] mem [N];
  logic [AW-1:0] flt_addr;
  logic [DW-1:0] sa0_mask;
  logic [DW-1:0] sa1_mask;

  always_ff @(posedge clk) begin
    if (mem_we)
      mem[mem_addr] <= (mem_addr == flt_addr) ? ((mem_wdata & ~sa0_mask) | sa1_mask) : mem_wdata;
    if (mem_re)
      mem_rdata <= mem[mem_addr];
  end

  int n_chk = 0;
  int n_err = 0;
  int op_cnt;
  int busy_cyc;
  int done_cnt;
  logic mon_on;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  typedef struct packed {
    logic          we;
    logic [AW-1:0] addr;
    logic [DW-1:0] wd;
  } op_t;

  op_t exp_q[$];

  // driver side: build the expected operation stream from the algorithm
  task automatic push_march();
    for (int e = 1; e <= 6; e++) begin
      for (int i = 0; i < N; i++) begin
        logic [AW-1:0] a;
        a = (e >= 4) ? AW'(N - 1 - i) : AW'(i);
        if (e != 1) exp_q.push_back('{we: 1'b0, addr: a, wd: '0});
        if (e != 6) exp_q.push_back('{we: 1'b1, addr: a,
                                       wd: (e == 2 || e == 4) ? {DW{1'b1}} : {DW{1'b0}}});
      end
    end
  endtask

  // monitor side: pop and compare each issued operation
  always @(negedge clk) begin
    if (busy) busy_cyc++;
    if (done) done_cnt++;
    if (mon_on && (mem_we || mem_re)) begin
      op_t got;
      op_t ex;
      op_cnt++;
      got = '{we: mem_we, addr: mem_addr, wd: mem_we ? mem_wdata : '0};
      if (exp_q.size() == 0) begin
        chk("R5 extra op", 32'(got), 32'hFFFF_FFFF);
      end else begin
        ex = exp_q.pop_front();
        chk("R2/R3/R4 op stream", 32'(got), 32'(ex));
      end
    end
  end

  task automatic pulse_start();
    @(posedge clk); #2 start = 1'b1;
    @(posedge clk); #2 start = 1'b0;
  endtask

  task automatic run_full(input string tag);
    exp_q.delete();
    push_march();
    op_cnt = 0; busy_cyc = 0; done_cnt = 0;
    mon_on = 1'b1;
    pulse_start();
    @(negedge clk);
    chk({tag, " R9 fail cleared"}, 32'(fail), 0);
    chk({tag, " R9 aborted cleared"}, 32'(aborted), 0);
    for (int c = 0; c < 5000 && !done; c++) @(negedge clk);
    mon_on = 1'b0;
    chk({tag, " R5 op count"}, op_cnt, 10 * N);
    chk({tag, " R5 queue drained"}, exp_q.size(), 0);
    chk({tag, " R7 busy cycles"}, busy_cyc, 10 * N + 1);
    chk({tag, " R7 busy low at done"}, 32'(busy), 0);
    @(negedge clk);
    chk({tag, " R7 done single pulse"}, done_cnt, 1);
  endtask

  initial begin
    #(20 * 150000);
    n_err++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    rst_n = 1'b0; dbg_en = 1'b0; start = 1'b0; mon_on = 1'b0;
    flt_addr = '0; sa0_mask = '0; sa1_mask = '0;
    op_cnt = 0; busy_cyc = 0; done_cnt = 0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("reset busy", 32'(busy), 0);
    chk("reset done", 32'(done), 0);
    chk("reset fail", 32'(fail), 0);
    chk("reset aborted", 32'(aborted), 0);

    // R1: start without debug enable is ignored
    pulse_start();
    repeat (5) @(negedge clk);
    chk("R1 no busy without dbg_en", 32'(busy), 0);
    chk("R1 no ops without dbg_en", 32'(mem_we | mem_re), 0);

    // clean run
    dbg_en = 1'b1;
    run_full("clean");
    chk("R6 clean no fail", 32'(fail), 0);
    begin
      int nz = 0;
      for (int i = 0; i < N; i++) if (mem[i] !== '0) nz++;
      chk("R10 memory left at zero", nz, 0);
    end

    // R6: stuck-at-0 at word 5 bit 2 -> first seen by element 3 read
    flt_addr = AW'(5); sa0_mask = 8'h04; sa1_mask = '0;
    run_full("sa0");
    chk("R6 sa0 fail", 32'(fail), 1);
    chk("R6 sa0 addr", 32'(fail_addr), 5);
    chk("R6 sa0 elem", 32'(fail_elem), 3);
    chk("R6 sa0 data", 32'(fail_data), 32'h0FB);

    // R6: stuck-at-1 at word 9 bit 7 -> first seen by element 2 read
    flt_addr = AW'(9); sa0_mask = '0; sa1_mask = 8'h80;
    run_full("sa1");
    chk("R6 sa1 fail", 32'(fail), 1);
    chk("R6 sa1 addr", 32'(fail_addr), 9);
    chk("R6 sa1 elem", 32'(fail_elem), 2);
    chk("R6 sa1 data", 32'(fail_data), 32'h080);
    sa1_mask = '0;

    // R8: abort in mid-run
    done_cnt = 0;
    pulse_start();
    repeat (30) @(negedge clk);
    chk("R8 running before abort", 32'(busy), 1);
    #1 dbg_en = 1'b0;
    @(negedge clk);
    chk("R8 busy cleared", 32'(busy), 0);
    chk("R8 aborted set", 32'(aborted), 1);
    chk("R8 no ops after abort", 32'(mem_we | mem_re), 0);
    repeat (5) @(negedge clk);
    chk("R8 no done after abort", done_cnt, 0);

    // R1: ignored start keeps aborted; R9: accepted start clears it
    pulse_start();
    repeat (3) @(negedge clk);
    chk("R1 ignored start keeps aborted", 32'(aborted), 1);
    chk("R1 ignored start keeps idle", 32'(busy), 0);
    dbg_en = 1'b1;
    run_full("after-abort");
    chk("R9 aborted cleared at end", 32'(aborted), 0);

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

endmodule